// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This controller sits between a clocked system bus and an external asynchronous 16-bit static RAM. The bus issues single-word requests with a request/ready handshake. Each request carries a direction flag, a 20-bit word address, 16-bit write data and a 2-bit lane mask. The controller turns each request into registered, glitch-free strobes for the RAM. The RAM has two selects of opposite polarity, an output-enable strobe, a write strobe, one enable per byte lane, and a data bus split into an output word, a driver enable and an input word.

Every timing minimum of the memory is a parameter in picoseconds. The controller rounds each minimum up to whole periods of the `CLK_PERIOD_PS` clock. No access is accepted until a power-up interval of `POWERUP_PS` has elapsed since reset. A read holds the address and enables for the access time, then samples the bus on the clock edge that ends the read. The word comes back with a one-cycle valid pulse, and lanes that were not requested read as zero. A write drives its data for the whole write-strobe pulse. The strobe, selects, lane enables and the data driver all release on one edge.

The sequencer has five states. ST_POWERUP waits for the power-up counter and then moves to ST_IDLE. ST_IDLE moves to ST_READ or ST_WRITE when a request is accepted. ST_READ moves to ST_TURN when its phase timer expires, and ST_TURN always returns to ST_IDLE after one cycle. ST_WRITE returns to ST_IDLE when its phase timer expires.

Top module: `asram_ctrl`

## Requirements
- R1: From reset until at least ceil(POWERUP_PS/CLK_PERIOD_PS) clock cycles have passed, `ready` is low and the memory is idle: `mem_sel_n`=1, `mem_sel`=0, `mem_rd_n`=1, `mem_wr_n`=1, `mem_drive`=0. `ready` rises no later than two cycles after that count.
- R2: A request is taken on a rising edge where `req` and `ready` are both high. `ready` is low in the cycle after acceptance. `req` has no effect while `ready` is low, including during power-up.
- R3: A read drives `mem_sel_n`=0, `mem_sel`=1, `mem_rd_n`=0 and `mem_wr_n`=1, with the requested address. The lane enables are `mem_lane_lo_n`=~mask[0] and `mem_lane_hi_n`=~mask[1]. These hold for RD_CYC = max(ceil(tAA), ceil(tRC)) cycles, which is 2 at defaults.
- R4: Read data is sampled on the edge that ends the read, and `rd_valid` is high for exactly one cycle after it. In `rd_data`, bits 7:0 follow mask[0] and bits 15:8 follow mask[1]; a lane whose mask bit is 0 reads as zero.
- R5: A write holds `mem_wr_n`=0 with both selects active and `mem_rd_n`=1 for WR_CYC = max(ceil(tPWE), ceil(tAW), ceil(tSD), ceil(tWC)-1) cycles, which is 2 at defaults. Address, lane enables and `mem_dout` stay stable, and `mem_drive` is high, for the whole pulse.
- R6: A write ends on a single edge. On that edge `mem_wr_n` rises, both selects go inactive, both lane enables go high and `mem_drive` falls, so hold time is zero.
- R7: After a write starts, the next access starts no sooner than WR_CYC+1 cycles later. This is never less than tWC.
- R8: `mem_drive` is never high while `mem_rd_n` is low. After a read, `mem_rd_n` stays high for at least two cycles before `mem_drive` can rise.
- R9: In a masked write, only lanes whose mask bit is 1 are stored. A write with mask 2'b00 leaves the word unchanged.
- R10: Whenever `ready` is high, both selects are inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask; bit 0 = bits 7:0, bit 1 = bits 15:8 |
| ready | output | 1 | Controller can accept a request |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds a new word |
| rd_data | output | 16 | Returned read word, unrequested lanes zero |
| mem_addr | output | 20 | Memory address |
| mem_sel_n | output | 1 | Active-low memory select |
| mem_sel | output | 1 | Active-high memory select |
| mem_rd_n | output | 1 | Active-low memory output enable |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_lane_lo_n | output | 1 | Active-low enable, bits 7:0 |
| mem_lane_hi_n | output | 1 | Active-low enable, bits 15:8 |
| mem_dout | output | 16 | Data toward the memory |
| mem_drive | output | 1 | Enable of the controller's bus driver |
| mem_din | input | 16 | Data from the memory bus |

## Verification
The bench measures strobe widths in clock cycles. A controller that rounded timing minimums down would give a read or write pulse one cycle short. A controller that dropped the turnaround state would raise its driver only one cycle after output enable returned high, and the bench checks for that gap. The memory model puts a fill pattern on lanes that are not enabled, so a controller that passed those lanes through instead of zeroing them returns wrong words. Masked and empty-mask writes are followed by read-back, which shows any write that disturbs a lane it should leave alone. Requests held high during power-up must leave the memory idle.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_POWERUP,
        ST_IDLE,
        ST_READ,
        ST_TURN,
        ST_WRITE
    } asram_state_e;

    function automatic int cdiv(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_pwrup.sv
module asram_pwrup #(
    parameter int LIMIT = 200000
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int W = $clog2(LIMIT + 2);

    logic [W-1:0] cnt_q;

    assign done = (cnt_q == W'(LIMIT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R1: once the wait is over it never restarts
    assert_pwrup_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

endmodule

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt_q;

    assign last = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val - 1'b1;
        end else if (!last) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // R3 / R5: a phase always lasts at least one cycle
    assert_phase_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0));

endmodule

// File: rtl/asram_rd_capture.sv
module asram_rd_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [1:0]        lane_en,
    input  logic [DATA_W-1:0] din,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    localparam int LANE_W = DATA_W / 2;

    logic [DATA_W-1:0] masked;

    for (genvar g = 0; g < 2; g++) begin : g_lane
        assign masked[g*LANE_W +: LANE_W] = lane_en[g] ? din[g*LANE_W +: LANE_W] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= fire;
            if (fire) begin
                rd_data <= masked;
            end
        end
    end

    // R4: the valid strobe is a single-cycle pulse
    assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W        = 20,
    parameter int DATA_W        = 16,
    parameter int CLK_PERIOD_PS = 5000,
    parameter int POWERUP_PS    = 1000000000,
    parameter int T_RC_PS       = 10000,
    parameter int T_AA_PS       = 10000,
    parameter int T_WC_PS       = 10000,
    parameter int T_PWE_PS      = 7000,
    parameter int T_AW_PS       = 7000,
    parameter int T_SD_PS       = 5500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_mask,
    output logic              ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic              mem_lane_lo_n,
    output logic              mem_lane_hi_n,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_drive,
    input  logic [DATA_W-1:0] mem_din
);
    localparam int PWR_CYC = cdiv(POWERUP_PS, CLK_PERIOD_PS);
    localparam int RD_CYC  = imax(1, imax(cdiv(T_AA_PS, CLK_PERIOD_PS),
                                          cdiv(T_RC_PS, CLK_PERIOD_PS)));
    localparam int WR_CYC  = imax(1, imax(imax(cdiv(T_PWE_PS, CLK_PERIOD_PS),
                                               cdiv(T_AW_PS, CLK_PERIOD_PS)),
                                          imax(cdiv(T_SD_PS, CLK_PERIOD_PS),
                                               cdiv(T_WC_PS, CLK_PERIOD_PS) - 1)));
    localparam int TMR_W   = $clog2(imax(RD_CYC, WR_CYC) + 1);

    asram_state_e    st_q, st_d;
    logic            pwr_done;
    logic            tmr_last;
    logic            accept;
    logic            cap_fire;
    logic [1:0]      mask_q;
    logic [TMR_W-1:0] tmr_val;

    assign ready    = (st_q == ST_IDLE);
    assign accept   = req && ready;
    assign tmr_val  = req_wr ? TMR_W'(WR_CYC) : TMR_W'(RD_CYC);
    assign cap_fire = (st_q == ST_READ) && tmr_last;

    asram_pwrup #(.LIMIT(PWR_CYC)) u_pwrup (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (pwr_done)
    );

    asram_phase_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    asram_rd_capture #(.DATA_W(DATA_W)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (cap_fire),
        .lane_en  (mask_q),
        .din      (mem_din),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_POWERUP: if (pwr_done) st_d = ST_IDLE;
            ST_IDLE:    if (req)      st_d = req_wr ? ST_WRITE : ST_READ;
            ST_READ:    if (tmr_last) st_d = ST_TURN;
            ST_TURN:                  st_d = ST_IDLE;
            ST_WRITE:   if (tmr_last) st_d = ST_IDLE;
            default:                  st_d = ST_POWERUP;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_POWERUP;
        end else begin
            st_q <= st_d;
        end
    end

    // registered strobes, decoded from the state being entered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_addr      <= '0;
            mem_dout      <= '0;
            mask_q        <= '0;
            mem_sel_n     <= 1'b1;
            mem_sel       <= 1'b0;
            mem_rd_n      <= 1'b1;
            mem_wr_n      <= 1'b1;
            mem_lane_lo_n <= 1'b1;
            mem_lane_hi_n <= 1'b1;
            mem_drive     <= 1'b0;
        end else begin
            if (accept) begin
                mem_addr      <= req_addr;
                mem_dout      <= req_wdata;
                mask_q        <= req_mask;
                mem_lane_lo_n <= ~req_mask[0];
                mem_lane_hi_n <= ~req_mask[1];
            end
            unique case (st_d)
                ST_READ: begin
                    mem_sel_n <= 1'b0;
                    mem_sel   <= 1'b1;
                    mem_rd_n  <= 1'b0;
                    mem_wr_n  <= 1'b1;
                    mem_drive <= 1'b0;
                end
                ST_WRITE: begin
                    mem_sel_n <= 1'b0;
                    mem_sel   <= 1'b1;
                    mem_rd_n  <= 1'b1;
                    mem_wr_n  <= 1'b0;
                    mem_drive <= 1'b1;
                end
                ST_POWERUP, ST_IDLE, ST_TURN: begin
                    mem_sel_n     <= 1'b1;
                    mem_sel       <= 1'b0;
                    mem_rd_n      <= 1'b1;
                    mem_wr_n      <= 1'b1;
                    mem_drive     <= 1'b0;
                    mem_lane_lo_n <= 1'b1;
                    mem_lane_hi_n <= 1'b1;
                end
                default: begin
                    mem_sel_n <= 1'b1;
                    mem_sel   <= 1'b0;
                    mem_rd_n  <= 1'b1;
                    mem_wr_n  <= 1'b1;
                    mem_drive <= 1'b0;
                end
            endcase
        end
    end

    // R1: no acceptance before the power-up counter has expired
    assert_ready_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> pwr_done);

    // R2: acceptance takes ready away for the next cycle
    assert_accept_drops_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !ready);

    // R4: sampling only happens while the memory is driving the bus
    assert_capture_in_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fire |-> (!mem_rd_n && mem_wr_n && !mem_sel_n && mem_sel));

    // R5: write strobe only with both selects active and own driver on
    assert_write_selected_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |-> (!mem_sel_n && mem_sel && mem_rd_n && mem_drive));

    // R5: address, data and lanes frozen during the pulse
    assert_write_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_wr_n && $past(!mem_wr_n)) |->
        ($stable(mem_addr) && $stable(mem_dout) && $stable({mem_lane_hi_n, mem_lane_lo_n})));

    // R6: all write terms release on one edge
    assert_release_together_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_n) |-> (mem_sel_n && !mem_sel && mem_lane_lo_n && mem_lane_hi_n && !mem_drive));

    // R8: never drive against the memory
    assert_no_contention_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_drive |-> mem_rd_n);

    // R8: driver stays off right after output enable was low
    assert_turnaround_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!mem_rd_n) |-> !mem_drive);

    // R10: idle controller leaves the memory deselected
    assert_idle_deselect_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (mem_sel_n && !mem_sel));

endmodule

// File: tb/tb_asram_ctrl.sv
`timescale 1ns/1ps
module tb_asram_ctrl;

    localparam int CLK_PS   = 5000;
    localparam int PWR_PS   = 2000000;
    localparam int PWR_EXP  = (PWR_PS + CLK_PS - 1) / CLK_PS;
    localparam int RD_EXP   = 2;   // max(ceil(10ns/5ns), ceil(10ns/5ns))
    localparam int WR_EXP   = 2;   // max(ceil 7, ceil 7, ceil 5.5, ceil 10 - 1) over 5ns
    localparam int WC_NS    = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_wr = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        ready, rd_valid;
    logic [15:0] rd_data;
    logic [19:0] mem_addr;
    logic        mem_sel_n, mem_sel, mem_rd_n, mem_wr_n, mem_lane_lo_n, mem_lane_hi_n;
    logic [15:0] mem_dout;
    logic        mem_drive;
    logic [15:0] mem_din;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    bit mon_on   = 0;

    always #2.5 clk = ~clk;

    asram_ctrl #(.CLK_PERIOD_PS(CLK_PS), .POWERUP_PS(PWR_PS)) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_mask(req_mask), .ready(ready), .rd_valid(rd_valid),
        .rd_data(rd_data), .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .mem_lane_lo_n(mem_lane_lo_n),
        .mem_lane_hi_n(mem_lane_hi_n), .mem_dout(mem_dout), .mem_drive(mem_drive),
        .mem_din(mem_din)
    );

    function automatic logic [15:0] fill_word(input int i);
        return 16'(i * 257) ^ 16'h5A5A;
    endfunction

    function automatic logic [15:0] lane_merge(input logic [15:0] old, input logic [15:0] nw,
                                               input logic [1:0] m);
        return {m[1] ? nw[15:8] : old[15:8], m[0] ? nw[7:0] : old[7:0]};
    endfunction

    function automatic logic [15:0] read_expect(input logic [15:0] w, input logic [1:0] m);
        return {m[1] ? w[15:8] : 8'h00, m[0] ? w[7:0] : 8'h00};
    endfunction

    // behavioural memory: lanes not enabled show a fill pattern
    logic [15:0] ram [256];
    logic [15:0] shadow [256];
    logic        msel;
    assign msel = !mem_sel_n && mem_sel;

    initial begin
        for (int i = 0; i < 256; i++) begin
            ram[i]    = fill_word(i);
            shadow[i] = fill_word(i);
        end
    end

    always_comb begin
        if (msel && !mem_rd_n && mem_wr_n)
            mem_din = {!mem_lane_hi_n ? ram[mem_addr[7:0]][15:8] : 8'hA5,
                       !mem_lane_lo_n ? ram[mem_addr[7:0]][7:0]  : 8'hA5};
        else
            mem_din = 16'hC3C3;
    end

    always @(posedge clk) begin
        if (msel && !mem_wr_n && mem_drive) begin
            if (!mem_lane_lo_n) ram[mem_addr[7:0]][7:0]  <= mem_dout[7:0];
            if (!mem_lane_hi_n) ram[mem_addr[7:0]][15:8] <= mem_dout[15:8];
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // strobe-width monitor
    int  we_cnt = 0, oe_cnt = 0, oe_hi = 100, gap = 100;
    bit  p_we = 1, p_oe = 1, p_drv = 0, p_rv = 0, p_sel_n = 1, last_wr = 0;

    always @(negedge clk) begin
        if (mon_on) begin
            if (!mem_wr_n) we_cnt++;
            else if (!p_we) begin
                check(we_cnt == WR_EXP, "R5 write pulse width", we_cnt, WR_EXP);
                check(mem_sel_n && !mem_sel && mem_lane_lo_n && mem_lane_hi_n && !mem_drive,
                      "R6 joint release", {mem_sel_n, mem_sel, mem_lane_lo_n, mem_lane_hi_n, mem_drive},
                      5'b10110);
                we_cnt = 0;
            end
            if (!mem_rd_n) oe_cnt++;
            else if (!p_oe) begin
                check(oe_cnt == RD_EXP, "R3 read strobe width", oe_cnt, RD_EXP);
                oe_cnt = 0;
            end
            if (mem_drive && !p_drv)
                check(oe_hi >= 2, "R8 turnaround gap", oe_hi, 2);
            if (mem_drive)
                check(mem_rd_n, "R8 contention", mem_rd_n, 1);
            if (rd_valid && p_rv)
                check(0, "R4 valid longer than one cycle", 2, 1);
            if (!mem_sel_n && p_sel_n) begin
                if (last_wr)
                    check(gap >= WR_EXP + 1 && gap * CLK_PS >= WC_NS * 1000,
                          "R7 write cycle time", gap, WR_EXP + 1);
                last_wr = !mem_wr_n;
                gap = 1;
            end else if (gap < 1000) gap++;
            oe_hi = mem_rd_n ? ((oe_hi < 1000) ? oe_hi + 1 : oe_hi) : 0;
            p_we = mem_wr_n; p_oe = mem_rd_n; p_drv = mem_drive;
            p_rv = rd_valid; p_sel_n = mem_sel_n;
        end
    end

    task automatic access(input bit wr, input logic [19:0] a, input logic [15:0] d,
                          input logic [1:0] m);
        logic [15:0] exp;
        @(negedge clk);
        while (!ready) @(negedge clk);
        check(mem_sel_n && !mem_sel, "R10 idle deselect", {mem_sel_n, mem_sel}, 2'b10);
        req = 1; req_wr = wr; req_addr = a; req_wdata = d; req_mask = m;
        @(negedge clk);
        req = 0;
        check(!ready, "R2 ready drops after accept", ready, 0);
        check(mem_addr == a, wr ? "R5 address" : "R3 address", mem_addr, a);
        check({mem_lane_hi_n, mem_lane_lo_n} == ~m, wr ? "R5 lane enables" : "R3 lane enables",
              {mem_lane_hi_n, mem_lane_lo_n}, ~m);
        if (wr) begin
            check(!mem_wr_n && mem_rd_n && mem_dout == d, "R5 write strobes",
                  {mem_wr_n, mem_rd_n, mem_dout}, {2'b01, d});
            shadow[a[7:0]] = lane_merge(shadow[a[7:0]], d, m);
        end else begin
            check(!mem_rd_n && mem_wr_n && !mem_sel_n && mem_sel, "R3 read strobes",
                  {mem_rd_n, mem_wr_n, mem_sel_n, mem_sel}, 4'b0101);
            while (!rd_valid) @(negedge clk);
            exp = read_expect(shadow[a[7:0]], m);
            check(rd_data == exp, (m == 2'b11) ? "R9 R4 read data" : "R4 masked read data",
                  rd_data, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int  k;
        bit  touched;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(!ready && mem_sel_n && !mem_sel && mem_rd_n && mem_wr_n && !mem_drive,
              "R1 reset state", {ready, mem_sel_n, mem_sel, mem_rd_n, mem_wr_n, mem_drive},
              6'b010110);
        // R2: requests during power-up are ignored
        k = 1; touched = 0;
        req = 1; req_wr = 1; req_addr = 20'h3; req_wdata = 16'hFFFF; req_mask = 2'b11;
        repeat (100) begin
            @(negedge clk); k++;
            if (!mem_sel_n || mem_sel || !mem_wr_n || ready) touched = 1;
        end
        req = 0;
        check(!touched, "R2 request ignored in power-up", touched, 0);
        while (!ready && k < 2 * PWR_EXP) begin @(negedge clk); k++; end
        check(k >= PWR_EXP && k <= PWR_EXP + 2, "R1 power-up length", k, PWR_EXP);
        mon_on = 1;

        // directed corner cases
        access(1, 20'h00000, 16'h1234, 2'b11);
        access(0, 20'h00000, 16'h0000, 2'b11);
        access(1, 20'h00000, 16'hABCD, 2'b01);   // R9 low lane only
        access(0, 20'h00000, 16'h0000, 2'b11);
        access(1, 20'h00000, 16'h77FF, 2'b10);   // R9 high lane only
        access(1, 20'h00000, 16'h9999, 2'b00);   // R9 no lanes
        access(0, 20'h00000, 16'h0000, 2'b11);
        access(0, 20'h00000, 16'h0000, 2'b01);   // R4 upper zeroed
        access(0, 20'h00000, 16'h0000, 2'b10);   // R4 lower zeroed
        access(0, 20'h00000, 16'h0000, 2'b00);
        access(1, 20'hFFFFF, 16'h0F0F, 2'b11);
        access(0, 20'hFFFFF, 16'h0000, 2'b11);
        access(1, 20'h00001, 16'h5555, 2'b11);   // R8 read then write right after
        access(0, 20'h00001, 16'h0000, 2'b11);
        access(0, 20'h00001, 16'h0000, 2'b11);

        // constrained random traffic
        for (int i = 0; i < 400; i++) begin
            logic [19:0] a;
            a = 20'($urandom % 16) | ((($urandom % 2) == 1) ? 20'hFFF00 : 20'h0);
            access(1'($urandom % 2), a, 16'($urandom), 2'($urandom));
        end
        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule